// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the 16x oversampling tick that drives a UART's shifters. It counts qualified cycles of a reference clock, where a reference enable marks the cycles that count. A tick is due after an integer number of those cycles, and the integer divisor is 16 bits wide. A 6-bit fractional divisor, expressed in 64ths, is spread over successive tick periods through a wrapping accumulator. As a result, the long-run average period is the integer divisor plus the fraction over 64 reference cycles.

Software works out both divisor values from the wanted baud rate and presents them on the divisor inputs. A write strobe copies them into the block's working registers and restarts the period counter and the accumulator. The tick output is a one-cycle pulse that the transmit and receive logic consume.

Top module: `frac_baud_gen`

## Requirements
- R1: `tick_o` is a registered single-cycle pulse. It is high for one clock only, and only when `uart_en` and a non-zero integer divisor were present in the cycle before.
- R2: With a fractional divisor of 0, every tick period is exactly the integer divisor, counted in cycles where `ref_en` is high.
- R3: Over any 64 consecutive tick periods, the number of counted reference cycles equals 64 times the integer divisor plus the fractional divisor.
- R4: Each tick adds the fractional divisor to a 6-bit accumulator that wraps. When that addition carries out of bit 5, the next period lasts one extra reference cycle. The first period after a restart is never stretched, so it is exactly the integer divisor.
- R5: A loaded integer divisor of 0 stops tick generation, and `tick_o` stays low whatever the fractional divisor is.
- R6: While `uart_en` is low, no tick is produced and the counter and accumulator are held at zero. After `uart_en` rises, the first tick arrives after exactly the integer divisor of counted cycles.
- R7: Changes on `div_int_i` or `div_frac_i` have no effect on the tick period until `div_load` is pulsed.
- R8: When `div_load` is high in a cycle, the divisor inputs are captured and the counter and accumulator restart from zero. The first tick then follows after the new integer divisor of counted cycles.
- R9: Only cycles with `ref_en` high advance the period. If `ref_en` is high every other clock, every period takes twice as many clocks.
- R10: A synchronous reset clears both divisors to 0, so no tick appears until a divisor is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference cycle qualifier; only these cycles are counted |
| uart_en | input | 1 | UART enable; low holds the generator idle |
| div_int_i | input | 16 | Integer divisor value to be loaded |
| div_frac_i | input | 6 | Fractional divisor value in 64ths, to be loaded |
| div_load | input | 1 | Write strobe that captures the divisors and restarts |
| tick_o | output | 1 | Single-cycle oversampling tick |

## Verification
A wrong count limit or a missed restart appears within one tick period: the first tick after a load or an enable comes early or late. An accumulator fault, such as a lost carry, a wrong addend or a missing wrap, leaves single periods looking plausible. It shows only as a wrong total over a 64-tick window, so that window is measured for several mixes of integer and fractional values, both with a continuous and with a gated reference enable. Loads of zero, a disabled UART, and input changes without a strobe are each watched at the tick output over a span longer than any expected period.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int INT_W  = 16;
    localparam int FRAC_W = 6;
    localparam int CNT_W  = INT_W + 1;

    typedef logic [INT_W-1:0]  int_div_t;
    typedef logic [FRAC_W-1:0] frac_div_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        int_div_t  whole;
        frac_div_t part;
    } div_cfg_t;

    // Last count value of a period of (whole + stretch) qualified cycles.
    function automatic cnt_t period_last(input int_div_t whole, input logic stretch);
        cnt_t span;
        span = {1'b0, whole} + cnt_t'(stretch);
        return span - cnt_t'(1);
    endfunction

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
    import frac_baud_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/frac_baud_accum.sv
module frac_baud_accum
    import frac_baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      wrap,
    input  frac_div_t part,
    output logic      stretch
);

    frac_div_t              acc_q;
    logic [FRAC_W:0]        sum;

    assign sum = {1'b0, acc_q} + {1'b0, part};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q   <= '0;
            stretch <= 1'b0;
        end else if (wrap) begin
            acc_q   <= sum[FRAC_W-1:0];
            stretch <= sum[FRAC_W];
        end
    end

endmodule

// File: rtl/frac_baud_counter.sv
module frac_baud_counter
    import frac_baud_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     ref_en,
    input  int_div_t whole,
    input  logic     stretch,
    output logic     wrap,
    output logic     tick
);

    cnt_t cnt_q;
    cnt_t last;

    assign last = period_last(whole, stretch);
    assign wrap = ref_en && !restart && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= wrap;
            if (restart || wrap) begin
                cnt_q <= '0;
            end else if (ref_en) begin
                cnt_q <= cnt_q + cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_en,
    input  logic        uart_en,
    input  logic [15:0] div_int_i,
    input  logic [5:0]  div_frac_i,
    input  logic        div_load,
    output logic        tick_o
);

    div_cfg_t cfg_in;
    div_cfg_t cfg_q;
    logic     running;
    logic     restart;
    logic     wrap;
    logic     stretch;

    assign cfg_in.whole = div_int_i;
    assign cfg_in.part  = div_frac_i;

    frac_baud_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .load   (div_load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    assign running = uart_en && (cfg_q.whole != '0);
    assign restart = div_load || !running;

    frac_baud_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .ref_en  (ref_en),
        .whole   (cfg_q.whole),
        .stretch (stretch),
        .wrap    (wrap),
        .tick    (tick_o)
    );

    frac_baud_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .wrap    (wrap),
        .part    (cfg_q.part),
        .stretch (stretch)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk
    import frac_baud_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     ref_en,
    input logic     uart_en,
    input logic     div_load,
    input logic     tick_o,
    input div_cfg_t cfg_q,
    input logic     stretch,
    input cnt_t     cnt_q
);

    AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(uart_en)); // R6
    AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(ref_en)); // R9
    AST_TICK_NONZERO_DIV: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> ($past(cfg_q.whole) != '0)); // R5
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> !$past(div_load)); // R8
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.whole != '0) |-> (cnt_q < ({1'b0, cfg_q.whole} + cnt_t'(stretch)))); // R2
    AST_ZERO_DIV_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.whole == '0) |-> (cnt_q == '0)); // R5
    AST_NO_STRETCH_WITHOUT_FRAC: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.part == '0) |-> !stretch); // R4
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(uart_en) |-> (cnt_q == '0 && !stretch)); // R6

endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_en   (ref_en),
    .uart_en  (uart_en),
    .div_load (div_load),
    .tick_o   (tick_o),
    .cfg_q    (cfg_q),
    .stretch  (stretch),
    .cnt_q    (u_counter.cnt_q)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        uart_en = 1'b0;
    logic [15:0] div_int = '0;
    logic [5:0]  div_frac = '0;
    logic        div_load = 1'b0;
    logic        gate_mode = 1'b0;
    logic        gate_ph = 1'b0;
    logic        ref_en;
    logic        tick_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) gate_ph <= ~gate_ph;
    assign ref_en = gate_mode ? gate_ph : 1'b1;

    frac_baud_gen u_frac_baud_gen (
        .clk        (clk),
        .rst        (rst),
        .ref_en     (ref_en),
        .uart_en    (uart_en),
        .div_int_i  (div_int),
        .div_frac_i (div_frac),
        .div_load   (div_load),
        .tick_o     (tick_o)
    );

    // {integer divisor, fractional divisor}
    localparam logic [21:0] VEC [6] = '{
        {16'd1,  6'd5},
        {16'd3,  6'd0},
        {16'd2,  6'd63},
        {16'd7,  6'd32},
        {16'd1,  6'd0},
        {16'd16, 6'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_o && n < limit);
        if (!tick_o) n = -1;
    endtask

    task automatic count_ticks(input int span, output int n);
        n = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (tick_o) n++;
        end
    endtask

    task automatic load_div(input int w, input int f);
        div_int  = 16'(w);
        div_frac = 6'(f);
        div_load = 1'b1;
        @(negedge clk);
        div_load = 1'b0;
    endtask

    initial begin
        int n;
        int total;
        int w;
        int f;
        repeat (3) @(negedge clk);
        check("R10 tick low in reset", int'(tick_o), 0);
        rst = 1'b0;
        uart_en = 1'b1;
        count_ticks(40, n);
        check("R10 no tick before a divisor is loaded", n, 0);

        for (int v = 0; v < 6; v++) begin
            w = int'(VEC[v][21:6]);
            f = int'(VEC[v][5:0]);
            load_div(w, f);
            wait_tick(5000, n);
            check("R4 first period after restart", n, w);
            total = 0;
            for (int k = 0; k < 64; k++) begin
                wait_tick(5000, n);
                total += n;
                if (f == 0 && k < 4) check("R2 period with zero fraction", n, w);
            end
            check("R3 64-tick window total", total, 64 * w + f);
        end

        // R1: pulse lasts one cycle
        load_div(3, 0);
        wait_tick(100, n);
        @(negedge clk);
        check("R1 tick drops after one cycle", int'(tick_o), 0);

        // R4: stretch pattern with half fraction
        load_div(1, 32);
        wait_tick(100, n);
        check("R4 first period unstretched", n, 1);
        wait_tick(100, n);
        check("R4 period after no carry", n, 1);
        wait_tick(100, n);
        check("R4 period after carry", n, 2);

        // R9: gated reference enable
        gate_mode = 1'b1;
        load_div(3, 0);
        wait_tick(200, n);
        wait_tick(200, n);
        check("R9 gated period doubles", n, 6);
        load_div(2, 16);
        wait_tick(500, n);
        total = 0;
        for (int k = 0; k < 64; k++) begin
            wait_tick(500, n);
            total += n;
        end
        check("R9 gated 64-tick window", total, 2 * (64 * 2 + 16));
        gate_mode = 1'b0;

        // R5: zero integer divisor
        load_div(0, 7);
        count_ticks(300, n);
        check("R5 no tick with zero integer divisor", n, 0);

        // R7: inputs ignored without strobe
        load_div(4, 0);
        wait_tick(100, n);
        div_int  = 16'd9;
        div_frac = 6'd11;
        wait_tick(100, n);
        check("R7 period unchanged without strobe", n, 4);

        // R8: strobe mid-period restarts with new value
        @(negedge clk);
        load_div(9, 0);
        wait_tick(100, n);
        check("R8 first tick after load", n, 9);
        wait_tick(100, n);
        check("R8 new period in effect", n, 9);

        // R6: disable holds, re-enable restarts
        load_div(5, 3);
        wait_tick(100, n);
        @(negedge clk);
        @(negedge clk);
        uart_en = 1'b0;
        count_ticks(60, n);
        check("R6 no tick while disabled", n, 0);
        uart_en = 1'b1;
        wait_tick(100, n);
        check("R6 first tick after re-enable", n, 5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule